// File: doc/BRIEF.md
# Interrupt Acknowledge Bus Sequencer

Once the processor has accepted an interrupt, it needs a type number to index its vector table. This block obtains that number in one of two ways. When the on-chip controller owns the interrupt, the block takes the type from `int_type_i` with no bus activity. When an off-chip controller owns it, the block runs a locked pair of acknowledge bus cycles and takes the type from the low data byte of the bus.

Each acknowledge cycle steps through T1, T2, T3 and T4. The ready input stretches T3 with wait states. A fixed number of idle clocks separates the two cycles, and only the second cycle supplies the type byte. The block finishes every request with a single-clock `done_o` pulse, with the type valid on `type_o`. Requests are taken only while the block is idle.

Top module: `intack_seq`

## Requirements
- R1: When `req_i` is sampled high in idle with `src_ext_i`=0, `done_o` is high in the very next clock. `type_o` then equals `int_type_i` as sampled with the request. `ale_o`, `inta_o` and `lock_o` stay low for the whole request.
- R2: When `req_i` is sampled high in idle with `src_ext_i`=1, exactly two acknowledge cycles run. Each is T1, T2, T3, T4 (plus waits). `inta_o` is high in every clock of both cycles. `ale_o` is high only in T1, so each request gives two ALE clocks.
- R3: In T3, each clock edge that samples `ready_i` low keeps the cycle in T3. This adds one clock of `inta_o` per low sample, in either acknowledge cycle.
- R4: Exactly two clocks separate T4 of the first cycle from T1 of the second. In those clocks `inta_o` is low and `lock_o` is high.
- R5: `lock_o` is high from T1 of the first cycle through T4 of the second. It is low in the `done_o` clock and in idle.
- R6: `type_o` takes `ad_i` at the edge that ends T3 of the second cycle, the edge where `ready_i` is sampled high. Values on `ad_i` during the first cycle, during wait states and after that edge are ignored.
- R7: `rd_o` stays low at all times.
- R8: On the external path, `done_o` is high for one clock, 11 clocks after the request edge plus one clock per wait state.
- R9: A request that arrives while a sequence runs, including in the `done_o` clock, is ignored. It produces neither an extra `done_o` nor bus activity.
- R10: While `rst_ni` is low, all strobes are low and `type_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Interrupt accepted, type needed |
| src_ext_i | input | 1 | 1: off-chip controller supplies type; 0: on-chip |
| int_type_i | input | 8 | Type from the on-chip controller |
| ready_i | input | 1 | Bus ready, sampled in T3 |
| ad_i | input | 8 | Low data byte of the bus |
| ale_o | output | 1 | Address latch enable, high in T1 |
| inta_o | output | 1 | Acknowledge strobe, high during T1..T4 |
| rd_o | output | 1 | Read strobe, held low |
| lock_o | output | 1 | Internal bus lock |
| done_o | output | 1 | One-clock completion pulse |
| type_o | output | 8 | Interrupt type, valid with `done_o` |

## Verification
The bench changes `ad_i` in every clock except the capture clock of the second cycle. A design that latched the byte in the first cycle, during a wait state or in T4 would return the wrong type.

Wait states are placed separately in each cycle. This catches a sequencer that ignores ready in one of the cycles: its latency and INTA clock count come out wrong.

Requests are raised mid-sequence and in the done clock itself. A design that re-armed early would give an extra done pulse.

The bench also counts the idle clocks in the gap and samples lock in the done clock. This exposes a gap of the wrong length and a lock released too early or held too late.

// File: rtl/intack_pkg.sv
package intack_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_T1,
    PH_T2,
    PH_T3,
    PH_T4,
    PH_GAP,
    PH_DONE
  } phase_e;

  typedef struct packed {
    logic ale;
    logic inta;
    logic rd;
    logic lock;
  } bus_ctl_t;

endpackage

// File: rtl/intack_phase_fsm.sv
module intack_phase_fsm
  import intack_pkg::*;
#(
  parameter int unsigned GAP_STATES = 2,
  parameter int unsigned NUM_CYC    = 2
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   req_i,
  input  logic   src_ext_i,
  input  logic   ready_i,
  output phase_e phase_o,
  output logic   accept_int_o,
  output logic   capture_o
);

  localparam int unsigned GW = (GAP_STATES > 1) ? $clog2(GAP_STATES) : 1;
  localparam int unsigned CW = (NUM_CYC > 1) ? $clog2(NUM_CYC) : 1;
  localparam logic [GW-1:0] GAP_LOAD = GW'(GAP_STATES - 1);
  localparam logic [CW-1:0] CYC_LAST = CW'(NUM_CYC - 1);

  phase_e        phase_q, phase_d;
  logic [GW-1:0] gap_q, gap_d;
  logic [CW-1:0] cyc_q, cyc_d;
  logic          last_cyc;

  assign last_cyc = (cyc_q == CYC_LAST);

  always_comb begin
    phase_d = phase_q;
    gap_d   = gap_q;
    cyc_d   = cyc_q;
    unique case (phase_q)
      PH_IDLE: begin
        if (req_i) begin
          cyc_d   = '0;
          phase_d = src_ext_i ? PH_T1 : PH_DONE;
        end
      end
      PH_T1: phase_d = PH_T2;
      PH_T2: phase_d = PH_T3;
      PH_T3: if (ready_i) phase_d = PH_T4;
      PH_T4: begin
        if (last_cyc) begin
          phase_d = PH_DONE;
        end else begin
          cyc_d   = cyc_q + 1'b1;
          gap_d   = GAP_LOAD;
          phase_d = PH_GAP;
        end
      end
      PH_GAP: begin
        if (gap_q == '0) phase_d = PH_T1;
        else             gap_d   = gap_q - 1'b1;
      end
      PH_DONE: phase_d = PH_IDLE;
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      gap_q   <= '0;
      cyc_q   <= '0;
    end else begin
      phase_q <= phase_d;
      gap_q   <= gap_d;
      cyc_q   <= cyc_d;
    end
  end

  assign phase_o      = phase_q;
  assign accept_int_o = (phase_q == PH_IDLE) && req_i && !src_ext_i;
  // type byte only in the final cycle, on the edge that leaves T3
  assign capture_o    = (phase_q == PH_T3) && ready_i && last_cyc;

endmodule

// File: rtl/intack_bus_decode.sv
module intack_bus_decode
  import intack_pkg::*;
(
  input  phase_e   phase_i,
  output bus_ctl_t ctl_o
);

  logic in_cycle;

  assign in_cycle = (phase_i == PH_T1) || (phase_i == PH_T2) ||
                    (phase_i == PH_T3) || (phase_i == PH_T4);

  always_comb begin
    ctl_o      = '0;
    ctl_o.ale  = (phase_i == PH_T1);
    ctl_o.inta = in_cycle;
    ctl_o.rd   = 1'b0;
    ctl_o.lock = in_cycle || (phase_i == PH_GAP);
  end

endmodule

// File: rtl/intack_type_latch.sv
module intack_type_latch #(
  parameter int unsigned TYPE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_int_i,
  input  logic [TYPE_W-1:0] int_type_i,
  input  logic              capture_i,
  input  logic [TYPE_W-1:0] ad_i,
  output logic [TYPE_W-1:0] type_o
);

  logic [TYPE_W-1:0] type_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         type_q <= '0;
    else if (load_int_i) type_q <= int_type_i;
    else if (capture_i)  type_q <= ad_i;
  end

  assign type_o = type_q;

endmodule

// File: rtl/intack_seq.sv
module intack_seq
  import intack_pkg::*;
#(
  parameter int unsigned TYPE_W     = 8,
  parameter int unsigned GAP_STATES = 2,
  parameter int unsigned NUM_CYC    = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              src_ext_i,
  input  logic [TYPE_W-1:0] int_type_i,
  input  logic              ready_i,
  input  logic [TYPE_W-1:0] ad_i,
  output logic              ale_o,
  output logic              inta_o,
  output logic              rd_o,
  output logic              lock_o,
  output logic              done_o,
  output logic [TYPE_W-1:0] type_o
);

  phase_e   phase_w;
  logic     accept_int_w;
  logic     capture_w;
  bus_ctl_t ctl_w;

  intack_phase_fsm #(
    .GAP_STATES(GAP_STATES),
    .NUM_CYC   (NUM_CYC)
  ) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_i       (req_i),
    .src_ext_i   (src_ext_i),
    .ready_i     (ready_i),
    .phase_o     (phase_w),
    .accept_int_o(accept_int_w),
    .capture_o   (capture_w)
  );

  intack_bus_decode u_dec (
    .phase_i(phase_w),
    .ctl_o  (ctl_w)
  );

  intack_type_latch #(
    .TYPE_W(TYPE_W)
  ) u_type (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_int_i(accept_int_w),
    .int_type_i(int_type_i),
    .capture_i (capture_w),
    .ad_i      (ad_i),
    .type_o    (type_o)
  );

  assign ale_o  = ctl_w.ale;
  assign inta_o = ctl_w.inta;
  assign rd_o   = ctl_w.rd;
  assign lock_o = ctl_w.lock;
  assign done_o = (phase_w == PH_DONE);

endmodule

// File: rtl/intack_seq_chk.sv
module intack_seq_chk
  import intack_pkg::*;
#(
  parameter int unsigned TYPE_W     = 8,
  parameter int unsigned GAP_STATES = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              src_ext_i,
  input logic              ready_i,
  input phase_e            phase_i,
  input logic              ale_o,
  input logic              inta_o,
  input logic              lock_o,
  input logic              done_o,
  input logic [TYPE_W-1:0] type_o
);

  logic [7:0] gap_run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                gap_run_q <= '0;
    else if (phase_i == PH_GAP) gap_run_q <= gap_run_q + 1'b1;
    else                        gap_run_q <= '0;
  end

  a_r1_internal_next: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_i == PH_IDLE && req_i && !src_ext_i) |=> (done_o && !lock_o && !inta_o));

  a_r2_ale_inside_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ale_o |-> (inta_o && lock_o));

  a_r3_wait_holds_t3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_i == PH_T3 && !ready_i) |=> (phase_i == PH_T3 && inta_o));

  a_r4_gap_length: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_i == PH_T1 && gap_run_q != 0) |-> (gap_run_q == GAP_STATES[7:0]));

  a_r4_gap_locked_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_i == PH_GAP) |-> (lock_o && !inta_o));

  a_r5_unlocked_at_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !lock_o);

  a_r6_type_loads_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(type_o) |-> ($past(phase_i == PH_T3 && ready_i) ||
                          $past(phase_i == PH_IDLE && req_i)));

  a_r8_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r9_done_returns_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (phase_i == PH_IDLE && !inta_o));

endmodule

bind intack_seq intack_seq_chk #(
  .TYPE_W    (TYPE_W),
  .GAP_STATES(GAP_STATES)
) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .req_i    (req_i),
  .src_ext_i(src_ext_i),
  .ready_i  (ready_i),
  .phase_i  (phase_w),
  .ale_o    (ale_o),
  .inta_o   (inta_o),
  .lock_o   (lock_o),
  .done_o   (done_o),
  .type_o   (type_o)
);

// File: tb/intack_seq_tb.sv
module intack_seq_tb;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       req_i = 1'b0;
  logic       src_ext_i = 1'b0;
  logic [7:0] int_type_i = '0;
  logic       ready_i = 1'b0;
  logic [7:0] ad_i = '0;
  logic       ale_o, inta_o, rd_o, lock_o, done_o;
  logic [7:0] type_o;

  intack_seq u_dut (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .req_i     (req_i),
    .src_ext_i (src_ext_i),
    .int_type_i(int_type_i),
    .ready_i   (ready_i),
    .ad_i      (ad_i),
    .ale_o     (ale_o),
    .inta_o    (inta_o),
    .rd_o      (rd_o),
    .lock_o    (lock_o),
    .done_o    (done_o),
    .type_o    (type_o)
  );

  always #10 clk_i = ~clk_i;  // 50 MHz

  typedef struct {
    logic [7:0] ty;
    int         lat;
    bit         ext;
    int         waits;
  } exp_t;

  exp_t q[$];
  int n_chk = 0, n_err = 0, n_done = 0, n_req = 0;
  int cyc_cnt = 0, t_req = 0;
  int acyc = 0, kk = 0, w_first = 0, w_second = 0;
  logic [7:0] ad_want = '0;
  int n_ale = 0, n_inta = 0, n_gap = 0, n_rd = 0;

  task automatic chk(bit ok, string tag, int act, int expv);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  always @(posedge clk_i) begin
    cyc_cnt <= cyc_cnt + 1;
    if (cyc_cnt > 20000) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc_cnt, 0);
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  // responder (off-chip controller) and monitor
  always @(negedge clk_i) begin
    if (rst_ni) begin
      if (ale_o) begin
        acyc = acyc + 1;
        kk = 0;
      end else if (inta_o) begin
        kk = kk + 1;
      end
      if (ale_o) n_ale++;
      if (inta_o) n_inta++;
      if (lock_o && !inta_o) n_gap++;
      if (rd_o) n_rd++;
      begin
        int wneed;
        wneed = (acyc == 1) ? w_first : w_second;
        ready_i = inta_o && (kk >= 2 + wneed);
        ad_i = (inta_o && acyc == 2 && kk == 2 + wneed) ? ad_want : (~ad_want ^ 8'(kk));
      end
      if (done_o) begin
        n_done++;
        if (q.size() == 0) begin
          chk(1'b0, "R9 unexpected done", 1, 0);
        end else begin
          exp_t e;
          e = q.pop_front();
          chk(type_o == e.ty, e.ext ? "R6 captured type" : "R1 internal type", int'(type_o), int'(e.ty));
          chk((cyc_cnt - t_req) == e.lat, e.ext ? "R8/R3 done latency" : "R1 done latency",
              cyc_cnt - t_req, e.lat);
          chk(n_ale == (e.ext ? 2 : 0), "R2 ALE clocks", n_ale, e.ext ? 2 : 0);
          chk(n_inta == (e.ext ? 8 + e.waits : 0), "R2/R3 INTA clocks", n_inta, e.ext ? 8 + e.waits : 0);
          chk(n_gap == (e.ext ? 2 : 0), "R4 locked idle gap", n_gap, e.ext ? 2 : 0);
          chk(!lock_o, "R5 lock low at done", int'(lock_o), 0);
          chk(n_rd == 0, "R7 rd stays low", n_rd, 0);
        end
      end
    end
  end

  task automatic run_req(bit ext, logic [7:0] ty, int w1, int w2, bit busy);
    exp_t e;
    @(negedge clk_i);
    e.ty = ty; e.ext = ext; e.waits = w1 + w2;
    e.lat = ext ? 11 + w1 + w2 : 1;
    q.push_back(e);
    n_req++;
    n_ale = 0; n_inta = 0; n_gap = 0; n_rd = 0;
    acyc = 0; kk = 0; w_first = w1; w_second = w2; ad_want = ty;
    int_type_i = ext ? ~ty : ty;
    src_ext_i = ext;
    t_req = cyc_cnt;
    req_i = 1'b1;
    @(negedge clk_i);
    if (!(busy && !ext)) req_i = 1'b0;
    int_type_i = ~ty ^ 8'h3C;
    if (busy) begin
      if (ext) begin
        repeat (4) @(negedge clk_i);
        src_ext_i = 1'b0;
        req_i = 1'b1;  // R9 mid-sequence
        @(negedge clk_i);
        req_i = 1'b0;
        while (!done_o) @(negedge clk_i);
        req_i = 1'b1;  // R9 during done clock
        src_ext_i = 1'b1;
        @(negedge clk_i);
        req_i = 1'b0;
      end else begin
        @(negedge clk_i);  // held through done clock (R9)
        req_i = 1'b0;
      end
    end
    while (q.size() != 0) @(negedge clk_i);
    repeat (3) @(negedge clk_i);
  endtask

  initial begin
    repeat (2) @(negedge clk_i);
    chk({ale_o, inta_o, rd_o, lock_o, done_o} == 5'b0, "R10 strobes in reset",
        int'({ale_o, inta_o, rd_o, lock_o, done_o}), 0);
    chk(type_o == 8'h00, "R10 type in reset", int'(type_o), 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    chk({ale_o, inta_o, lock_o, done_o} == 4'b0, "R10 idle after reset",
        int'({ale_o, inta_o, lock_o, done_o}), 0);

    run_req(1'b0, 8'h5A, 0, 0, 1'b0);  // R1
    run_req(1'b1, 8'h21, 0, 0, 1'b0);  // R2 R4 R6 R8
    run_req(1'b1, 8'h96, 2, 0, 1'b0);  // R3 first cycle waits
    run_req(1'b1, 8'h0F, 0, 3, 1'b0);  // R3 second cycle waits, R6
    run_req(1'b0, 8'hFF, 0, 0, 1'b0);  // R1 after external
    run_req(1'b1, 8'hC3, 1, 1, 1'b1);  // R9 busy requests
    run_req(1'b0, 8'h81, 0, 0, 1'b1);  // R9 held request

    repeat (20) @(negedge clk_i);
    chk(q.size() == 0, "R9 no missing done", q.size(), 0);
    chk(n_done == n_req, "R9 done count", n_done, n_req);
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

endmodule